// File: doc/BRIEF.md
# DMA Channel Error Capture Registers

This block records error events raised by two DMA channels in a pair of 32-bit status registers. The first-error register takes the events of the earliest cycle in which any error occurs, and then it locks. While it is locked, every later event is ORed into the next-error register. Software reads either register through a simple read/write port. It clears bits by writing ones to them. When the first-error register has been cleared completely, it unlocks and takes the next event again.

Errors that other logic detects (parity, address range, writes to read-only descriptor registers) arrive as one-cycle pulses on a per-bit event input. The block does one check of its own. When a channel loads a next-descriptor pointer whose five low address bits are not all zero, the block raises that channel's alignment error. The status bits survive the ordinary core reset. Only the separate sticky reset clears them.

Top module: `errcap_regs`

## Requirements
- R1: After the sticky reset, both the first-error and the next-error register read as zero.
- R2: Each channel owns one byte, channel c at bits 8c+7..8c. Inside that byte the bits are: bit 0, write to a read-only descriptor register; bit 1, source data parity; bit 3, destination address; bit 5, source address; bit 6, pointer alignment; bit 7, pointer addressing. Byte bits 2 and 4, and register bits 16 to 31, always read as zero, even when their event inputs are pulsed.
- R3: While the first-error register is zero, an event cycle sets the matching bits of the first-error register and leaves the next-error register unchanged. Several events in the same cycle are all captured together.
- R4: While the first-error register is non-zero, events do not change it. They set the matching bits of the next-error register instead.
- R5: The next-error register accumulates. Each event ORs its bits in, and the bits stay set until they are cleared.
- R6: A write with reg_sel=0 (first-error register) or reg_sel=1 (next-error register) clears every defined bit written as 1 and leaves every bit written as 0 unchanged.
- R7: Once software has cleared all bits of the first-error register, the next event is captured in the first-error register again.
- R8: If an event and a clearing write hit the same bit of the same register in one cycle, the bit stays set.
- R9: The core reset leaves both error registers unchanged. While the core reset is active, reg_rdata reads zero.
- R10: A pulse on ptr_load[c] with ptr_addr bits [4:0] of channel c non-zero sets that channel's alignment bit (byte bit 6). A pointer with bits [4:0] all zero sets nothing. The alignment positions of err_ev are ignored.
- R11: reg_rdata shows, one clock later, the register chosen by reg_sel (0 = first-error, 1 = next-error), as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Core reset, active low, asynchronous; clears only the read data register |
| sticky_rst_n | input | 1 | Sticky reset, active low, asynchronous; clears both error registers |
| err_ev | input | 16 | One-cycle error pulses, one per status bit position |
| ptr_load | input | 2 | Per channel: a next-descriptor pointer is being loaded |
| ptr_addr | input | 64 | Per channel pointer address, channel c at bits 32c+31..32c |
| reg_wr | input | 1 | Write strobe for the write-one-to-clear port |
| reg_sel | input | 1 | Register select: 0 first-error, 1 next-error |
| reg_wdata | input | 32 | Write data; ones clear bits |
| reg_rdata | output | 32 | Registered read data |

## Verification
The bench pulses each of the sixteen event positions alone into a freshly reset block. This separates the defined bits from the reserved bits and from the alignment positions that are ignored. Each single pulse is followed by an all-ones pulse. That second pulse shows whether the first register locked and the rest went to the next register, or whether the register was still empty and took the whole burst. Every offset within a 32-byte line is tried on the pointer check of channel 0, and a few are tried on channel 1. This shows that only the five low bits matter. Ordered sequences then separate capture from accumulation, clear-one from keep-zero, unlock after a full clear, the set-wins case of an event and a clear in the same cycle, and core reset from sticky reset.

// File: rtl/errcap_regs.sv
module errcap_regs #(
  parameter int AW  = 32,
  parameter int NCH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sticky_rst_n,
  input  logic [8*NCH-1:0]  err_ev,
  input  logic [NCH-1:0]    ptr_load,
  input  logic [NCH*AW-1:0] ptr_addr,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  localparam int EW = 8 * NCH;
  localparam logic [7:0] CH_DEF = 8'hEB;
  localparam logic [7:0] CH_ALN = 8'h40;
  localparam logic [EW-1:0] DEF_M = {NCH{CH_DEF}};

  logic [EW-1:0] ev, ferr, nerr, clr_f, clr_n;
  logic          f_empty;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic misal;
    assign misal = ptr_load[c] && (ptr_addr[c*AW +: 5] != 5'd0);
    assign ev[c*8 +: 8] = (err_ev[c*8 +: 8] & CH_DEF & ~CH_ALN) | (misal ? CH_ALN : 8'h00);
  end

  assign f_empty = (ferr == '0);
  assign clr_f   = (reg_wr && !reg_sel) ? (reg_wdata[EW-1:0] & DEF_M) : '0;
  assign clr_n   = (reg_wr &&  reg_sel) ? (reg_wdata[EW-1:0] & DEF_M) : '0;

  always_ff @(posedge clk or negedge sticky_rst_n) begin
    if (!sticky_rst_n) begin
      ferr <= '0;
      nerr <= '0;
    end else begin
      ferr <= (ferr & ~clr_f) | (f_empty ? ev : '0);
      nerr <= (nerr & ~clr_n) | (f_empty ? '0 : ev);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= {{(32-EW){1'b0}}, (reg_sel ? nerr : ferr)};
  end
endmodule

module errcap_chk #(
  parameter int EW = 16,
  parameter int NCH = 2,
  parameter logic [EW-1:0] DEF = 16'hEBEB
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sticky_rst_n,
  input logic          reg_wr,
  input logic          reg_sel,
  input logic [EW-1:0] err_ev,
  input logic [NCH-1:0] ptr_load,
  input logic [EW-1:0] ferr,
  input logic [EW-1:0] nerr
);
  localparam logic [EW-1:0] ALN = {NCH{8'h40}};

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!sticky_rst_n)
    ((ferr & ~DEF) == '0) && ((nerr & ~DEF) == '0)); // R2

  AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (!sticky_rst_n)
    (ferr == '0 && (err_ev & DEF & ~ALN) != '0) |=> (ferr != '0)); // R3

  AST_FIRST_LOCK: assert property (@(posedge clk) disable iff (!sticky_rst_n)
    (ferr != '0 && !(reg_wr && !reg_sel)) |=> $stable(ferr)); // R4

  AST_NEXT_ACCUM: assert property (@(posedge clk) disable iff (!sticky_rst_n)
    !(reg_wr && reg_sel) |=> ((nerr & $past(nerr)) == $past(nerr))); // R5

  AST_CORE_RST_KEEP: assert property (@(posedge clk) disable iff (!sticky_rst_n)
    (!rst_n && !reg_wr && err_ev == '0 && ptr_load == '0) |=> ($stable(ferr) && $stable(nerr))); // R9
endmodule

bind errcap_regs errcap_chk #(.EW(EW), .NCH(NCH), .DEF(DEF_M)) u_chk (
  .clk(clk), .rst_n(rst_n), .sticky_rst_n(sticky_rst_n), .reg_wr(reg_wr),
  .reg_sel(reg_sel), .err_ev(err_ev), .ptr_load(ptr_load), .ferr(ferr), .nerr(nerr)
);

// File: tb/sim_errcap_regs.sv
module sim_errcap_regs;
  localparam logic [31:0] DEF = 32'h0000_EBEB;
  localparam logic [31:0] ALN = 32'h0000_4040;

  logic        clk = 0, rst_n = 1, sticky_rst_n = 1;
  logic [15:0] err_ev = '0;
  logic [1:0]  ptr_load = '0;
  logic [63:0] ptr_addr = '0;
  logic        reg_wr = 0, reg_sel = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  int checks = 0, errors = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  errcap_regs u0 (.clk(clk), .rst_n(rst_n), .sticky_rst_n(sticky_rst_n), .err_ev(err_ev),
    .ptr_load(ptr_load), .ptr_addr(ptr_addr), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic [15:0] ev, logic wr, logic sel, logic [31:0] wd,
                     logic [1:0] ld, logic [63:0] pa);
    @(negedge clk);
    err_ev = ev; reg_wr = wr; reg_sel = sel; reg_wdata = wd; ptr_load = ld; ptr_addr = pa;
    @(posedge clk);
    @(negedge clk);
    err_ev = '0; reg_wr = 0; reg_wdata = '0; ptr_load = '0;
  endtask

  task automatic pulse(logic [15:0] ev);
    cyc(ev, 0, 0, '0, 2'b00, '0);
  endtask

  task automatic rd(logic sel, output logic [31:0] val);
    @(negedge clk);
    reg_sel = sel;
    @(posedge clk);
    @(negedge clk);
    val = reg_rdata;
  endtask

  task automatic sreset();
    @(negedge clk);
    sticky_rst_n = 0;
    @(posedge clk);
    @(negedge clk);
    sticky_rst_n = 1;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1; rst_n = 0; sticky_rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1; sticky_rst_n = 1;

    rd(0, v); chk("R1 first after sticky reset", v, 0);
    rd(1, v); chk("R1 next after sticky reset", v, 0);

    for (int i = 0; i < 16; i++) begin
      logic [31:0] e1;
      sreset();
      e1 = (32'h1 << i) & DEF & ~ALN;
      pulse(16'h1 << i);
      rd(0, v); chk($sformatf("R2/R3/R10 first bit %0d", i), v, e1);
      rd(1, v); chk($sformatf("R3 next untouched bit %0d", i), v, 0);
      pulse(16'hFFFF);
      if (e1 != 0) begin
        rd(0, v); chk($sformatf("R4 first locked bit %0d", i), v, e1);
        rd(1, v); chk($sformatf("R4 next gets burst bit %0d", i), v, DEF & ~ALN);
      end else begin
        rd(0, v); chk($sformatf("R3 empty first takes burst bit %0d", i), v, DEF & ~ALN);
        rd(1, v); chk($sformatf("R3 next empty bit %0d", i), v, 0);
      end
    end

    sreset();
    pulse(16'h0903);
    rd(0, v); chk("R3 simultaneous capture", v, 32'h0903);
    pulse(16'h0001); pulse(16'h0002); pulse(16'h0100);
    rd(1, v); chk("R5 next accumulates", v, 32'h0103);
    rd(0, v); chk("R4 first still locked", v, 32'h0903);

    cyc('0, 1, 0, 32'h0000_0001, 2'b00, '0);
    rd(0, v); chk("R6 clear one bit of first", v, 32'h0902);
    cyc('0, 1, 0, 32'h0, 2'b00, '0);
    rd(0, v); chk("R6 zero write keeps first", v, 32'h0902);
    cyc('0, 1, 1, 32'h0000_0101, 2'b00, '0);
    rd(1, v); chk("R6 clear bits of next", v, 32'h0002);

    cyc('0, 1, 0, 32'hFFFF_FFFF, 2'b00, '0);
    rd(0, v); chk("R6 full clear of first", v, 0);
    pulse(16'h0020);
    rd(0, v); chk("R7 first unlocked and recaptures", v, 32'h0020);
    rd(1, v); chk("R7 next unchanged by recapture", v, 32'h0002);

    cyc(16'h0020, 1, 1, 32'h0000_0020, 2'b00, '0);
    rd(1, v); chk("R8 event beats clear on next", v, 32'h0022);
    rd(0, v); chk("R8 first unaffected", v, 32'h0020);

    @(negedge clk); reg_sel = 0; rst_n = 0;
    @(posedge clk); @(negedge clk);
    chk("R9 rdata zero in core reset", reg_rdata, 0);
    @(posedge clk); @(negedge clk); rst_n = 1;
    rd(0, v); chk("R9 first survives core reset", v, 32'h0020);
    rd(1, v); chk("R9 next survives core reset", v, 32'h0022);
    rd(1, v); chk("R11 read of next", v, 32'h0022);

    for (int off = 0; off < 32; off++) begin
      sreset();
      cyc('0, 0, 0, '0, 2'b01, {32'h0, 32'h1000 + off});
      rd(0, v); chk($sformatf("R10 ch0 offset %0d", off), v, (off != 0) ? 32'h0040 : 32'h0);
    end
    sreset();
    cyc('0, 0, 0, '0, 2'b10, {32'h2000, 32'h3});
    rd(0, v); chk("R10 ch1 aligned, ch0 not loaded", v, 0);
    cyc('0, 0, 0, '0, 2'b10, {32'h2004, 32'h0});
    rd(0, v); chk("R10 ch1 misaligned", v, 32'h4000);
    cyc('0, 0, 0, '0, 2'b11, {32'h2010, 32'h1001});
    rd(1, v); chk("R10 both channels into next", v, 32'h4040);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule